// File: doc/BRIEF.md
# Clock Mode Decoder and Divider Tree

This block turns four static strap pins into an operating mode for a system clock generator and produces the divided clock domains from one fast source clock. Three select pins (a rate select plus two spread selects) choose between an all-off state, a test state, and normal running at the high or low CPU rate. A fourth, active-low pin turns spread modulation on. The spread type is reported to an external modulator. The PLL and the modulator themselves sit outside the block.

The source clock `clk_in` carries twice the VCO rate in normal operation and the externally supplied test clock in test mode. Four divider lanes (CPU, 66 MHz domain, PCI, APIC) run from one phase counter and restart together at its wrap. Every domain therefore rises on the same edge once per frame. The decoded mode is latched only at that wrap, so a pin change never cuts a clock pulse short. The reference and USB outputs are taken from their own inputs in normal running and from the source clock in test mode.

Top module: `clk_mode_gen`

## Requirements
- R1: With `sel_hi_i`=0 and `sel1_i`=`sel0_i`=0, `core_oe_o` and `usb_oe_o` are 0 and every clock output stays 0 whatever `ref_in` and `usb_in` do.
- R2: With `sel_hi_i`=1 and `sel1_i`=`sel0_i`=0 (test), the CPU, 66, PCI and APIC outputs have periods of 2, 4, 8 and 16 `clk_in` cycles. `ref_clk_o` follows `clk_in`, `usb_clk_o` equals the CPU output, and `usb_pll_en_o` is 0.
- R3: With `sel_hi_i`=1 and (`sel1_i`,`sel0_i`) not 00, the four lanes have periods of 2, 4, 8 and 16 `clk_in` cycles, each high for half its period.
- R4: With `sel_hi_i`=0 and (`sel1_i`,`sel0_i`) not 00, the four lanes have periods of 4, 6, 12 and 24 `clk_in` cycles, each high for half its period.
- R5: `ss_active_o` is 1 only in normal running with `spread_n_i`=0. `ss_down_o` is 1 when spread is active and `sel1_i`=1; center spread is active with `ss_down_o`=0, which happens for (`sel1_i`,`sel0_i`)=01.
- R6: With `sel_hi_i`=0, `sel1_i`=1 and `sel0_i`=0, `usb_oe_o` and `usb_pll_en_o` are 0 and `usb_clk_o` stays 0. In every other normal-running combination they are 1 and `usb_clk_o` follows `usb_in`.
- R7: A new select or spread value takes effect on the edge where the phase counter wraps: 16 source cycles per frame at the high rate, 24 at the low rate. At every APIC rise, the CPU, 66 and PCI outputs rise in the same cycle.
- R8: During reset, all enables, spread outputs and clocks are 0. The first decoded mode appears on the 16th rising edge after reset is released.
- R9: In normal running, `ref_clk_o` follows `ref_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Source clock: twice the VCO rate, or the test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_hi_i | input | 1 | Rate select, 1 = high CPU rate |
| sel1_i | input | 1 | Spread/mode select, upper bit |
| sel0_i | input | 1 | Spread/mode select, lower bit |
| spread_n_i | input | 1 | Spread enable, active low |
| ref_in | input | 1 | Reference clock from the crystal oscillator |
| usb_in | input | 1 | 48 MHz clock from the USB PLL |
| cpu_clk_o | output | 1 | CPU domain clock |
| v66_clk_o | output | 1 | 66 MHz domain clock |
| pci_clk_o | output | 1 | PCI domain clock |
| apic_clk_o | output | 1 | APIC domain clock |
| ref_clk_o | output | 1 | Reference clock output |
| usb_clk_o | output | 1 | USB clock output |
| core_oe_o | output | 1 | Output enable for CPU, 66, PCI, APIC and reference pads |
| usb_oe_o | output | 1 | Output enable for the USB pad |
| usb_pll_en_o | output | 1 | Run request to the USB PLL |
| ss_active_o | output | 1 | Spread modulation on |
| ss_down_o | output | 1 | Spread type: 1 = down spread, 0 = center spread |

## Verification
A corrupted phase counter or lane counter shows up at the ports within one frame of at most 24 cycles. It appears as a lane whose rise count over a 48-cycle window is wrong, as a high time other than half the window, or as an APIC rise with a lower lane not rising beside it. A mode register that loads at the wrong time moves the enable edge away from the 16th cycle after a frame start. A wrong decode shows at once in the enables, the spread outputs or the USB PLL request after settling, and the bench covers all eight select patterns with both spread settings.

// File: rtl/clk_mode_pkg.sv
`timescale 1ns/1ps
package clk_mode_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_TEST = 2'd1,
        MODE_RUN  = 2'd2
    } run_mode_e;

    typedef struct packed {
        run_mode_e mode;
        logic      rate_hi;
        logic      ss_on;
        logic      ss_down;
        logic      usb_hold;
    } mode_cfg_t;

    localparam int NUM_LANES = 4;

endpackage

// File: rtl/clk_mode_decode.sv
`timescale 1ns/1ps
module clk_mode_decode
    import clk_mode_pkg::*;
(
    input  logic      sel_hi_i,
    input  logic      sel1_i,
    input  logic      sel0_i,
    input  logic      spread_n_i,
    output mode_cfg_t cfg_o
);

    always_comb begin
        cfg_o = '{mode: MODE_OFF, rate_hi: sel_hi_i, ss_on: 1'b0,
                  ss_down: 1'b0, usb_hold: 1'b0};
        if (sel1_i || sel0_i) begin
            cfg_o.mode     = MODE_RUN;
            cfg_o.ss_on    = !spread_n_i;
            cfg_o.ss_down  = !spread_n_i && sel1_i;
            cfg_o.usb_hold = !sel_hi_i && sel1_i && !sel0_i;
        end else if (sel_hi_i) begin
            cfg_o.mode = MODE_TEST;
        end
    end

endmodule

// File: rtl/clk_div_lane.sv
`timescale 1ns/1ps
module clk_div_lane #(
    parameter int HW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          restart_i,
    input  logic          en_i,
    input  logic [HW-1:0] half_i,
    output logic          clk_o
);

    localparam logic [HW:0] ONE = {{HW{1'b0}}, 1'b1};

    typedef struct packed {
        logic [HW:0] cnt;
        logic        lvl;
    } lane_st_t;

    lane_st_t    st_q, st_d;
    logic [HW:0] last_cnt;

    assign last_cnt = {half_i, 1'b0} - ONE;

    always_comb begin
        st_d = st_q;
        if (restart_i || st_q.cnt == last_cnt) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + ONE;
        end
        st_d.lvl = (st_d.cnt < {1'b0, half_i});
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0, lvl: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_o = st_q.lvl & en_i;

    // R7: every lane starts high right after a frame restart
    a_r7_high_after_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> st_q.lvl);

    // R3 / R4: level changes only at the start or the middle of a period
    a_r3_edge_at_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(st_q.lvl) |-> (st_q.cnt == '0 || st_q.cnt == {1'b0, half_i}));

endmodule

// File: rtl/clk_mode_gen.sv
`timescale 1ns/1ps
module clk_mode_gen
    import clk_mode_pkg::*;
#(
    parameter int CPU_HALF_HI = 1,
    parameter int CPU_HALF_LO = 2,
    parameter int V66_HALF_HI = 2,
    parameter int V66_HALF_LO = 3
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic sel_hi_i,
    input  logic sel1_i,
    input  logic sel0_i,
    input  logic spread_n_i,
    input  logic ref_in,
    input  logic usb_in,
    output logic cpu_clk_o,
    output logic v66_clk_o,
    output logic pci_clk_o,
    output logic apic_clk_o,
    output logic ref_clk_o,
    output logic usb_clk_o,
    output logic core_oe_o,
    output logic usb_oe_o,
    output logic usb_pll_en_o,
    output logic ss_active_o,
    output logic ss_down_o
);

    localparam int V66_MAX    = (V66_HALF_LO > V66_HALF_HI) ? V66_HALF_LO : V66_HALF_HI;
    localparam int HW         = $clog2(4 * V66_MAX + 1);
    localparam int PW         = $clog2(8 * V66_MAX);
    localparam int FRAME_HI   = 8 * V66_HALF_HI;
    localparam int FRAME_LO   = 8 * V66_HALF_LO;

    typedef struct packed {
        mode_cfg_t     cfg;
        logic [PW-1:0] phase;
    } top_st_t;

    top_st_t                st_q, st_d;
    mode_cfg_t              dec_cfg;
    logic [PW-1:0]          phase_last;
    logic                   wrap;
    logic [NUM_LANES-1:0]   lane_clk;
    logic                   core_on, test_on, usb_on;

    clk_mode_decode i_dec (
        .sel_hi_i   (sel_hi_i),
        .sel1_i     (sel1_i),
        .sel0_i     (sel0_i),
        .spread_n_i (spread_n_i),
        .cfg_o      (dec_cfg)
    );

    assign phase_last = st_q.cfg.rate_hi ? PW'(FRAME_HI - 1) : PW'(FRAME_LO - 1);
    assign wrap       = (st_q.phase == phase_last);

    always_comb begin
        st_d = st_q;
        if (wrap) begin
            st_d.phase = '0;
            st_d.cfg   = dec_cfg;
        end else begin
            st_d.phase = st_q.phase + {{(PW-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cfg: '{mode: MODE_OFF, rate_hi: 1'b1, ss_on: 1'b0,
                             ss_down: 1'b0, usb_hold: 1'b0},
                      phase: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign core_on = (st_q.cfg.mode != MODE_OFF);
    assign test_on = (st_q.cfg.mode == MODE_TEST);
    assign usb_on  = core_on && !st_q.cfg.usb_hold;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int HH = (g == 0) ? CPU_HALF_HI : V66_HALF_HI * (2 ** g) / 2;
        localparam int HL = (g == 0) ? CPU_HALF_LO : V66_HALF_LO * (2 ** g) / 2;
        logic [HW-1:0] half;
        assign half = st_q.cfg.rate_hi ? HW'(HH) : HW'(HL);
        clk_div_lane #(.HW(HW)) i_lane (
            .clk_i     (clk_in),
            .rst_ni    (rst_n),
            .restart_i (wrap),
            .en_i      (core_on),
            .half_i    (half),
            .clk_o     (lane_clk[g])
        );
    end

    assign cpu_clk_o    = lane_clk[0];
    assign v66_clk_o    = lane_clk[1];
    assign pci_clk_o    = lane_clk[2];
    assign apic_clk_o   = lane_clk[3];
    assign ref_clk_o    = core_on & (test_on ? clk_in : ref_in);
    assign usb_clk_o    = usb_on & (test_on ? lane_clk[0] : usb_in);
    assign core_oe_o    = core_on;
    assign usb_oe_o     = usb_on;
    assign usb_pll_en_o = (st_q.cfg.mode == MODE_RUN) && !st_q.cfg.usb_hold;
    assign ss_active_o  = st_q.cfg.ss_on;
    assign ss_down_o    = st_q.cfg.ss_down;

    // R7: configuration is held between frame boundaries
    a_r7_cfg_at_wrap: assert property (@(posedge clk_in) disable iff (!rst_n)
        (st_q.phase != phase_last) |=> $stable(st_q.cfg));

    // R7: lower lanes rise together with the APIC lane
    a_r7_lanes_aligned: assert property (@(posedge clk_in) disable iff (!rst_n)
        $rose(apic_clk_o) |-> (cpu_clk_o && v66_clk_o && pci_clk_o));

    // R5: a down-spread report implies spread is on, and only in normal running
    a_r5_down_needs_spread: assert property (@(posedge clk_in) disable iff (!rst_n)
        ss_down_o |-> (ss_active_o && usb_oe_o | ss_active_o));

    a_r5_spread_only_running: assert property (@(posedge clk_in) disable iff (!rst_n)
        ss_active_o |-> (core_oe_o && !(ref_clk_o === 1'bx)));

    // R6: the USB PLL never runs while its pad is disabled
    a_r6_pll_off_when_held: assert property (@(posedge clk_in) disable iff (!rst_n)
        !usb_oe_o |-> !usb_pll_en_o);

endmodule

// File: tb/test_clk_mode_gen.sv
`timescale 1ns/1ps
module test_clk_mode_gen;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_hi = 1'b0, sel1 = 1'b0, sel0 = 1'b0, spread_n = 1'b1;
    logic ref_in = 1'b0, usb_in = 1'b0;
    logic cpu_clk, v66_clk, pci_clk, apic_clk, ref_clk, usb_clk;
    logic core_oe, usb_oe, usb_pll_en, ss_active, ss_down;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    clk_mode_gen i_clk_mode_gen (
        .clk_in       (clk),
        .rst_n        (rst_n),
        .sel_hi_i     (sel_hi),
        .sel1_i       (sel1),
        .sel0_i       (sel0),
        .spread_n_i   (spread_n),
        .ref_in       (ref_in),
        .usb_in       (usb_in),
        .cpu_clk_o    (cpu_clk),
        .v66_clk_o    (v66_clk),
        .pci_clk_o    (pci_clk),
        .apic_clk_o   (apic_clk),
        .ref_clk_o    (ref_clk),
        .usb_clk_o    (usb_clk),
        .core_oe_o    (core_oe),
        .usb_oe_o     (usb_oe),
        .usb_pll_en_o (usb_pll_en),
        .ss_active_o  (ss_active),
        .ss_down_o    (ss_down)
    );

    function automatic void summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_period(input int lane, input bit sh);
        int hi_p[4] = '{2, 4, 8, 16};
        int lo_p[4] = '{4, 6, 12, 24};
        return sh ? hi_p[lane] : lo_p[lane];
    endfunction

    task automatic measure(input string tg, input bit sh, input bit on, input bit usb_cpu);
        logic [3:0] prev, cur;
        int rises[4] = '{default: 0};
        int highs[4] = '{default: 0};
        int misalign = 0;
        int usb_diff = 0;
        @(negedge clk);
        prev = {apic_clk, pci_clk, v66_clk, cpu_clk};
        for (int k = 0; k < 48; k++) begin
            @(negedge clk);
            cur = {apic_clk, pci_clk, v66_clk, cpu_clk};
            for (int l = 0; l < 4; l++) begin
                if (cur[l] && !prev[l]) rises[l]++;
                if (cur[l]) highs[l]++;
            end
            if (cur[3] && !prev[3] && (cur != 4'hF || prev != 4'h0)) misalign++;
            if (usb_cpu && (usb_clk != cpu_clk)) usb_diff++;
            prev = cur;
        end
        for (int l = 0; l < 4; l++) begin
            int er = on ? 48 / exp_period(l, sh) : 0;
            int eh = on ? 24 : 0;
            chk(rises[l] == er, tg, rises[l], er);
            chk(highs[l] == eh, tg, highs[l], eh);
        end
        chk(misalign == 0, "R7", misalign, 0);
        if (usb_cpu) chk(usb_diff == 0, "R2", usb_diff, 0);
    endtask

    task automatic full_check(input bit sh, input bit s1, input bit s0, input bit sp);
        bit on   = sh | s1 | s0;
        bit run  = s1 | s0;
        bit test = sh && !run;
        bit hold = !sh && s1 && !s0;
        string tg;
        tg = !on ? "R1" : (test ? "R2" : (sh ? "R3" : "R4"));
        @(negedge clk);
        sel_hi = sh; sel1 = s1; sel0 = s0; spread_n = sp;
        repeat (60) @(negedge clk);
        chk(core_oe == on, tg, core_oe, on);
        chk(usb_oe == (on && !hold), "R6", usb_oe, on && !hold);
        chk(usb_pll_en == (run && !hold), "R6", usb_pll_en, run && !hold);
        chk(ss_active == (run && !sp), "R5", ss_active, run && !sp);
        chk(ss_down == (run && !sp && s1), "R5", ss_down, run && !sp && s1);
        measure(tg, sh, on, test);
        if (test) begin
            @(posedge clk); #1;
            chk(ref_clk == 1'b1, "R2", ref_clk, 1);
            @(negedge clk); #1;
            chk(ref_clk == 1'b0, "R2", ref_clk, 0);
        end else begin
            @(negedge clk);
            ref_in = 1'b1; usb_in = 1'b1; #1;
            chk(ref_clk == on, on ? "R9" : "R1", ref_clk, on);
            chk(usb_clk == (on && !hold), on ? "R6" : "R1", usb_clk, on && !hold);
            ref_in = 1'b0; usb_in = 1'b0; #1;
            chk(ref_clk == 1'b0, on ? "R9" : "R1", ref_clk, 0);
            chk(usb_clk == 1'b0, on ? "R6" : "R1", usb_clk, 0);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        logic prev_apic;
        int seed_val;
        // R8: reset state
        sel_hi = 1'b1; sel1 = 1'b0; sel0 = 1'b1; spread_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(core_oe == 1'b0, "R8", core_oe, 0);
        chk(usb_pll_en == 1'b0 && ss_active == 1'b0, "R8", usb_pll_en | ss_active, 0);
        chk(cpu_clk == 1'b0 && apic_clk == 1'b0, "R8", cpu_clk | apic_clk, 0);
        rst_n = 1'b1;
        repeat (15) @(negedge clk);
        chk(core_oe == 1'b0, "R8", core_oe, 0);
        @(negedge clk);
        chk(core_oe == 1'b1, "R8", core_oe, 1);

        // all eight select patterns, spread on and off
        for (int m = 0; m < 16; m++) begin
            full_check(m[2], m[1], m[0], m[3]);
        end

        // R7: a select change lands exactly at the next frame wrap
        full_check(1'b1, 1'b0, 1'b1, 1'b1);
        prev_apic = apic_clk;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (apic_clk && !prev_apic) break;
            prev_apic = apic_clk;
        end
        sel_hi = 1'b0; sel1 = 1'b0; sel0 = 1'b0;
        repeat (15) @(negedge clk);
        chk(core_oe == 1'b1, "R7", core_oe, 1);
        @(negedge clk);
        chk(core_oe == 1'b0, "R7", core_oe, 0);

        // random select patterns from a fixed seed
        seed_val = $urandom(32'd20011);
        for (int it = 0; it < 24; it++) begin
            int r = $urandom;
            full_check(r[0], r[1], r[2], r[3]);
        end

        summary();
        $finish;
    end

endmodule